// File: doc/BRIEF.md
# Oversampling Serial Receiver with Late-Edge Resynchronization

This block receives asynchronous serial frames on a single line. The line is sampled once per pulse of a receive-clock enable that runs at sixteen times the bit rate. A cyclic sample counter tracks the position inside each bit. The value of each bit is decided by a majority vote of three samples taken around the middle of the bit. Disagreement among those three samples is reported as noise. A frame is a low start bit, eight data bits sent least significant first, and one stop bit.

A far-end transmitter that runs a little slow pushes the bit boundaries later and later. To keep the samples centred, the receiver watches for falling edges that arrive late inside a data bit. When it finds a valid one, it pulls the sample counter back to its first phase one bit period after that edge. The bit count is left unchanged. A control input switches this correction off.

The block has no register interface. A host collects each byte together with its noise and framing flags when the one-cycle strobe fires.

Top module: `uart_os_rx`

## Requirements
- R1: The sample counter holds a phase from 1 to 16. It advances only on a cycle where `smp_tick` is 1, and it wraps from 16 to 1. Phase 16 followed by phase 1 marks the move to the next bit.
- R2: While idle, a start is recognised on the tick whose sample of `rx_in` is 0, when the three samples before it were 1. That 0-sample is phase 1 of the start bit.
- R3: The value of every bit is the majority of the samples taken at phases 8, 9 and 10.
- R4: `rx_noise` is 1 at the strobe when, for any bit of the frame (start, data or stop), the three voted samples were not all equal. Otherwise it is 0.
- R5: A start bit voted 1 is a false start. The receiver returns to idle and gives no strobe for it.
- R6: Data bits arrive least significant bit first. The first data bit after the start bit lands in `rx_byte[0]`.
- R7: `rx_frame_err` is 1 at the strobe when the stop bit is voted 0, and 0 when it is voted 1.
- R8: `rx_valid` is high for exactly one clock cycle per received frame. `rx_byte`, `rx_noise` and `rx_frame_err` keep their values until the next strobe. After reset all four outputs are 0.
- R9: Resynchronization can only take place when `resync_off` is 0 at the time the edge is seen. With `resync_off` at 1, the counter runs freely through the frame.
- R10: A resynchronization needs all of the following. A falling edge inside a data bit: three 1-samples and then a 0-sample. That 0-sample at phase 1 to 8 of the bit. The previous bit voted 1. The current bit voted 0. When all of these hold, the phase is set to 1 exactly 16 ticks after the 0-sample, and the bit count does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_tick | input | 1 | Receive-clock enable, one pulse per oversample |
| rx_in | input | 1 | Serial receive line, idle high |
| resync_off | input | 1 | 1 disables data-bit resynchronization |
| rx_byte | output | 8 | Last received data byte |
| rx_valid | output | 1 | One-cycle strobe when a frame completes |
| rx_noise | output | 1 | Noise seen in the last frame |
| rx_frame_err | output | 1 | Stop bit of the last frame was voted 0 |

## Verification
All 256 byte values are sent at the nominal rate, with mixed stop-bit values and both settings of `resync_off`. A design that shifts MSB first, samples off-centre or mislabels the stop bit would return the wrong byte or the wrong error flag.

Glitches of one and two samples placed inside the voting window check the vote and the noise flag. Short low pulses check false-start handling: a design that skips the start vote would emit a spurious strobe.

A transmitter running at 17 ticks per bit checks the correction itself. With correction on, a pattern with early edges must come back clean. The same pattern with correction off, or a pattern whose only edge lands at phase 9, must show a framing error. A design that resyncs on the wrong phase window or ignores the control input fails these cases.

// File: rtl/uart_os_rx_pkg.sv
package uart_os_rx_pkg;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_e;

endpackage

// File: rtl/rx_vote3.sv
// Majority decision and disagreement flag over three samples.
module rx_vote3 (
    input  logic [2:0] samples,
    output logic       bit_val,
    output logic       disagree
);
    always_comb begin
        bit_val  = (samples[0] & samples[1]) | (samples[0] & samples[2]) |
                   (samples[1] & samples[2]);
        disagree = !((&samples) || !(|samples));
    end
endmodule

// File: rtl/rx_fall_det.sv
// Keeps the last RUN raw samples; flags a 0-sample that follows RUN 1-samples.
module rx_fall_det #(
    parameter int RUN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic line,
    output logic fall
);
    logic [RUN-1:0] hist_d, hist_q;

    always_comb begin
        hist_d = hist_q;
        if (tick) begin
            hist_d = {hist_q[RUN-2:0], line};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '1;
        end else begin
            hist_q <= hist_d;
        end
    end

    assign fall = tick && (&hist_q) && !line;
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx
    import uart_os_rx_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter int OSR       = 16,
    parameter int EDGE_RUN  = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_tick,
    input  logic                 rx_in,
    input  logic                 resync_off,
    output logic [DATA_BITS-1:0] rx_byte,
    output logic                 rx_valid,
    output logic                 rx_noise,
    output logic                 rx_frame_err
);
    localparam int PW       = $clog2(OSR + 1);
    localparam int IW       = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam int V_FIRST  = OSR / 2;
    localparam int V_MID    = OSR / 2 + 1;
    localparam int V_LAST   = OSR / 2 + 2;
    localparam int EDGE_MAX = OSR / 2;

    typedef struct packed {
        rx_state_e            st;
        logic [PW-1:0]        phase;
        logic [IW-1:0]        idx;
        logic [1:0]           smp;
        logic [DATA_BITS-1:0] shreg;
        logic                 last_bit;
        logic                 pend;
        logic [PW-1:0]        edge_ph;
        logic                 nacc;
        logic [DATA_BITS-1:0] data;
        logic                 valid;
        logic                 noise;
        logic                 ferr;
    } core_t;

    core_t r_d, r_q;

    logic          fall;
    logic          v_bit, v_noise;
    logic [PW-1:0] ph_nxt;
    logic          at_wrap;

    rx_fall_det #(.RUN(EDGE_RUN)) u_fall (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (smp_tick),
        .line (rx_in),
        .fall (fall)
    );

    rx_vote3 u_vote (
        .samples ({rx_in, r_q.smp[1], r_q.smp[0]}),
        .bit_val (v_bit),
        .disagree(v_noise)
    );

    assign at_wrap = (r_q.phase == PW'(OSR));
    assign ph_nxt  = at_wrap ? PW'(1) : r_q.phase + PW'(1);

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        if (smp_tick) begin
            if (r_q.st == RX_IDLE) begin
                if (fall) begin
                    r_d.st    = RX_START;
                    r_d.phase = PW'(1);
                    r_d.idx   = '0;
                    r_d.pend  = 1'b0;
                    r_d.nacc  = 1'b0;
                end
            end else begin
                r_d.phase = ph_nxt;
                if (at_wrap) begin
                    if (r_q.st == RX_START) begin
                        r_d.st  = RX_DATA;
                        r_d.idx = '0;
                    end else if (r_q.st == RX_DATA) begin
                        if (r_q.idx == IW'(DATA_BITS - 1)) begin
                            r_d.st = RX_STOP;
                        end else begin
                            r_d.idx = r_q.idx + IW'(1);
                        end
                    end
                end
                // late-edge realignment: one bit period after the edge
                if (r_q.pend && ph_nxt == r_q.edge_ph) begin
                    r_d.phase = PW'(1);
                    r_d.pend  = 1'b0;
                end
                if (ph_nxt == PW'(V_FIRST)) r_d.smp[0] = rx_in;
                if (ph_nxt == PW'(V_MID))   r_d.smp[1] = rx_in;
                if (ph_nxt == PW'(V_LAST)) begin
                    r_d.nacc     = r_q.nacc | v_noise;
                    r_d.last_bit = v_bit;
                    case (r_q.st)
                        RX_START: begin
                            if (v_bit) r_d.st = RX_IDLE;
                        end
                        RX_DATA: begin
                            r_d.shreg = {v_bit, r_q.shreg[DATA_BITS-1:1]};
                            if (!(r_q.last_bit && !v_bit)) r_d.pend = 1'b0;
                        end
                        default: begin
                            r_d.st    = RX_IDLE;
                            r_d.valid = 1'b1;
                            r_d.data  = r_q.shreg;
                            r_d.noise = r_q.nacc | v_noise;
                            r_d.ferr  = !v_bit;
                            r_d.pend  = 1'b0;
                        end
                    endcase
                end
                if (r_q.st == RX_DATA && fall && !resync_off && !r_q.pend &&
                    ph_nxt <= PW'(EDGE_MAX)) begin
                    r_d.pend    = 1'b1;
                    r_d.edge_ph = ph_nxt;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= RX_IDLE;
            r_q.phase <= PW'(1);
        end else begin
            r_q <= r_d;
        end
    end

    assign rx_byte      = r_q.data;
    assign rx_valid     = r_q.valid;
    assign rx_noise     = r_q.noise;
    assign rx_frame_err = r_q.ferr;

    // ---------------- assertions ----------------
    p_phase_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != RX_IDLE) |-> (r_q.phase >= PW'(1) && r_q.phase <= PW'(OSR)));

    p_hold_without_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_tick |=> $stable(r_q.phase));

    p_single_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    p_err_moves_with_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_frame_err != $past(rx_frame_err)) |-> rx_valid);

    p_arm_needs_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.pend) |-> $past(!resync_off));

    p_jump_needs_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != RX_IDLE && $past(r_q.st) != RX_IDLE && $past(smp_tick) &&
         r_q.phase == PW'(1) && $past(r_q.phase) != PW'(OSR)) |-> $past(r_q.pend));

    p_jump_keeps_bit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == RX_DATA && $past(r_q.st) == RX_DATA && $past(smp_tick) &&
         r_q.phase == PW'(1) && $past(r_q.phase) != PW'(OSR)) |-> (r_q.idx == $past(r_q.idx)));

endmodule

// File: tb/uart_os_rx_bench.sv
module uart_os_rx_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_tick = 1'b0;
    logic       rx_in = 1'b1;
    logic       resync_off = 1'b0;
    logic [7:0] rx_byte;
    logic       rx_valid, rx_noise, rx_frame_err;

    int n_tests = 0;
    int n_fail  = 0;
    int got_cnt = 0;
    int wide_strobe = 0;
    logic       prev_valid = 1'b0;
    logic [7:0] got_data = '0;
    logic       got_noise = 1'b0;
    logic       got_err = 1'b0;
    bit         finished = 1'b0;

    always #2 clk = ~clk;

    uart_os_rx u_uart_os_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_tick    (smp_tick),
        .rx_in       (rx_in),
        .resync_off  (resync_off),
        .rx_byte     (rx_byte),
        .rx_valid    (rx_valid),
        .rx_noise    (rx_noise),
        .rx_frame_err(rx_frame_err)
    );

    // strobe monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rx_valid) begin
            got_cnt   <= got_cnt + 1;
            got_data  <= rx_byte;
            got_noise <= rx_noise;
            got_err   <= rx_frame_err;
            if (prev_valid) wide_strobe <= wide_strobe + 1;
        end
        prev_valid <= rx_valid;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic one_tick();
        @(negedge clk) smp_tick = 1'b1;
        @(negedge clk) smp_tick = 1'b0;
    endtask

    task automatic tx_sym(input logic level, input int n);
        rx_in = level;
        for (int k = 0; k < n; k++) one_tick();
    endtask

    task automatic frame(input logic [7:0] b, input int bt, input logic stop);
        tx_sym(1'b0, bt);
        for (int i = 0; i < 8; i++) tx_sym(b[i], bt);
        tx_sym(stop, bt);
        tx_sym(1'b1, 24);
    endtask

    task automatic expect_frame(input int base, input logic [7:0] d, input logic nz,
                                input logic fe, input string tag);
        chk(got_cnt == base + 1, {"R8 strobe count ", tag}, got_cnt - base, 1);
        chk(got_data == d, {"R6 R3 R2 R1 byte ", tag}, got_data, d);
        chk(got_noise == nz, {"R4 noise ", tag}, got_noise, nz);
        chk(got_err == fe, {"R7 frame error ", tag}, got_err, fe);
    endtask

    initial begin
        #(4 * 190000);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int base;
        repeat (4) @(negedge clk);
        chk(rx_valid == 1'b0 && rx_byte == 8'h00 && rx_noise == 1'b0 && rx_frame_err == 1'b0,
            "R8 reset outputs", {rx_valid, rx_noise, rx_frame_err, rx_byte}, 0);
        rst_n = 1'b1;
        tx_sym(1'b1, 8);

        // sweep all bytes at nominal rate
        for (int v = 0; v < 256; v++) begin
            logic stop_v;
            stop_v = (v % 5) != 0;
            resync_off = v[0];
            base = got_cnt;
            frame(8'(v), 16, stop_v);
            expect_frame(base, 8'(v), 1'b0, !stop_v, "sweep");
        end
        resync_off = 1'b0;

        // false starts: R5
        base = got_cnt;
        tx_sym(1'b0, 3);
        tx_sym(1'b1, 30);
        chk(got_cnt == base, "R5 short low pulse strobe", got_cnt - base, 0);
        tx_sym(1'b0, 8);
        tx_sym(1'b1, 30);
        chk(got_cnt == base, "R5 low through phase 8 strobe", got_cnt - base, 0);
        base = got_cnt;
        frame(8'hA3, 16, 1'b1);
        expect_frame(base, 8'hA3, 1'b0, 1'b0, "R5 recovery");

        // one-sample glitch at phase 9 of data bit 3: value kept, noise set (R3 R4)
        base = got_cnt;
        tx_sym(1'b0, 72);
        tx_sym(1'b1, 1);
        tx_sym(1'b0, 71);
        tx_sym(1'b1, 40);
        expect_frame(base, 8'h00, 1'b1, 1'b0, "R4 single glitch");

        // two-sample glitch at phases 8,9 of data bit 3: value flips (R3)
        base = got_cnt;
        tx_sym(1'b0, 71);
        tx_sym(1'b1, 2);
        tx_sym(1'b0, 71);
        tx_sym(1'b1, 40);
        expect_frame(base, 8'h08, 1'b1, 1'b0, "R3 double glitch");

        // slow transmitter, 17 ticks per bit
        resync_off = 1'b0;
        base = got_cnt;
        frame(8'h55, 17, 1'b1);
        expect_frame(base, 8'h55, 1'b0, 1'b0, "R10 slow sender realigned");

        resync_off = 1'b1;
        base = got_cnt;
        frame(8'h55, 17, 1'b1);
        expect_frame(base, 8'h55, 1'b1, 1'b1, "R9 slow sender correction off");

        resync_off = 1'b0;
        base = got_cnt;
        frame(8'h7F, 17, 1'b1);
        expect_frame(base, 8'h7F, 1'b1, 1'b1, "R10 edge at phase 9 ignored");

        chk(wide_strobe == 0, "R8 strobe width", wide_strobe, 0);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule